// File: doc/BRIEF.md
# Edge-Programmable Input Capture Unit

The block timestamps transitions on up to four external signals. A free-running capture counter advances once every (P+1) clock cycles, where P is a prescale field in the control register. Each channel owns a two-bit edge selector. When the selected transition appears on a channel's input after synchronization, the current counter value is stored in that channel's capture register, and a status bit is raised for that channel.

Software uses a 32-bit register bus. It programs the prescale, the global run bit and the per-channel edge selectors. It then waits for the interrupt, reads the captured counts, and clears status through a write-one-to-clear acknowledge register. The status and enable fields sit at bits 4:1, so the all-ones mask 0x1FF clears every pending channel at once.

Top module: `cap_unit`

## Requirements
- R1: While reset is asserted and just after it is released, every readable register returns zero and `irq` is low.
- R2: The edge selector of channel c is bits 1:0 at address 0x30+4c. It reads back as written. Code 0 captures nothing, 1 captures rising transitions, 2 captures falling transitions and 3 captures both.
- R3: Each input passes through two synchronizing flops. A transition driven before clock edge k is acted on at edge k+2. That edge stores the counter value that was held during the preceding cycle.
- R4: The capture register of channel c reads at address 0x10+4c, zero-extended to 32 bits, and holds its value until the next capture on that channel.
- R5: The 32-bit counter advances by one every (P+1) clocks, where P is control bits 8:4 at address 0x50. It counts only while the run bit (control bit 10) is set, and it holds its value while the run bit is clear. The prescale divider restarts whenever the run bit is clear.
- R6: While the run bit is clear, no channel captures and no status bit sets.
- R7: A capture on channel c sets bit c+1 of the status register at 0x58, whether or not its interrupt is enabled.
- R8: Interrupt enables are bits 4:1 at 0x54. `irq` is high exactly when some status bit and its enable are both set.
- R9: A write to 0x5C clears every status bit whose position is set in the written data, so 0x1FF clears all of them. A capture in the same cycle as the acknowledge leaves its bit set.
- R10: The control register reads back only bits 10 and 8:4, with all other bits zero. The acknowledge address and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Asynchronous capture inputs, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
Two events can collide in one cycle: a synchronized edge detected on a channel, and a software write to either the acknowledge register or the edge selector. The bench provokes this by changing an input exactly two clocks before it issues the acknowledge or reprogramming write. The collision then lands on the same clock edge. The behavioural model applies the rules that the capture wins over the clear, and that detection uses the selector value from before the write. Every clock, the read data and `irq` are compared against that model.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam int OFF_CAPV    = 'h10;
  localparam int OFF_EDGE    = 'h30;
  localparam int OFF_CTRL    = 'h50;
  localparam int OFF_IEN     = 'h54;
  localparam int OFF_STS     = 'h58;
  localparam int OFF_ACK     = 'h5C;
  localparam int CH_STRIDE   = 4;
  localparam int CTL_RUN_BIT = 10;
  localparam int PSC_LSB     = 4;
  localparam int PSC_W       = 5;
  localparam int IRQ_LSB     = 1;
endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect import cap_pkg::*; #(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [NCH-1:0]       sig_in,
  input  logic [NCH-1:0][1:0]  sel,
  output logic [NCH-1:0]       hit_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic s1_q, s2_q, pv_q;
    logic rise, fall, match;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        pv_q <= 1'b0;
      end else begin
        s1_q <= sig_in[g];
        s2_q <= s1_q;
        pv_q <= s2_q;
      end
    end

    always_comb begin
      rise = s2_q & ~pv_q;
      fall = ~s2_q & pv_q;
      case (edge_sel_e'(sel[g]))
        EDGE_RISE: match = rise;
        EDGE_FALL: match = fall;
        EDGE_ANY:  match = rise | fall;
        default:   match = 1'b0;
      endcase
      hit_o[g] = arm & match;
    end
  end
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 32,
  parameter int PSC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  output logic [CNT_W-1:0] count
);
  logic [PSC_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (run) begin
      if (div_q == psc) begin
        div_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end else begin
      div_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit import cap_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    cap_in,
  output logic              irq
);
  logic [NCH-1:0][1:0] esel_q, esel_d;
  logic                run_q, run_d;
  logic [PSC_W-1:0]    psc_q, psc_d;
  logic [NCH-1:0]      ien_q, ien_d;
  logic [NCH-1:0]      sts_q, sts_d;
  logic [NCH-1:0]      hit_w;
  logic [CNT_W-1:0]    cnt_w;
  logic [CNT_W-1:0]    capv_q [NCH];
  logic [CNT_W-1:0]    capv_d [NCH];
  logic                wr_ctl, wr_ien, wr_ack;

  cap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .psc(psc_q), .count(cnt_w)
  );

  cap_edge_detect #(.NCH(NCH)) ed_i (
    .clk(clk), .rst_n(rst_n), .arm(run_q), .sig_in(cap_in),
    .sel(esel_q), .hit_o(hit_w)
  );

  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_ien = bus_wr && (bus_addr == ADDR_W'(OFF_IEN));
  assign wr_ack = bus_wr && (bus_addr == ADDR_W'(OFF_ACK));

  always_comb begin
    run_d  = run_q;
    psc_d  = psc_q;
    ien_d  = ien_q;
    esel_d = esel_q;
    sts_d  = sts_q;
    if (wr_ctl) begin
      run_d = bus_wdata[CTL_RUN_BIT];
      psc_d = bus_wdata[PSC_LSB +: PSC_W];
    end
    if (wr_ien) ien_d = bus_wdata[IRQ_LSB +: NCH];
    if (wr_ack) sts_d = sts_q & ~bus_wdata[IRQ_LSB +: NCH];
    sts_d = sts_d | hit_w;
    for (int c = 0; c < NCH; c++) begin
      if (bus_wr && (bus_addr == ADDR_W'(OFF_EDGE + CH_STRIDE * c)))
        esel_d[c] = bus_wdata[1:0];
      capv_d[c] = hit_w[c] ? cnt_w : capv_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      psc_q  <= '0;
      ien_q  <= '0;
      esel_q <= '0;
      sts_q  <= '0;
      for (int c = 0; c < NCH; c++) capv_q[c] <= '0;
    end else begin
      run_q  <= run_d;
      psc_q  <= psc_d;
      ien_q  <= ien_d;
      esel_q <= esel_d;
      sts_q  <= sts_d;
      for (int c = 0; c < NCH; c++) capv_q[c] <= capv_d[c];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(OFF_CAPV + CH_STRIDE * c)) bus_rdata[CNT_W-1:0] = capv_q[c];
      if (bus_addr == ADDR_W'(OFF_EDGE + CH_STRIDE * c)) bus_rdata[1:0] = esel_q[c];
    end
    if (bus_addr == ADDR_W'(OFF_CTRL)) begin
      bus_rdata[CTL_RUN_BIT]         = run_q;
      bus_rdata[PSC_LSB +: PSC_W]    = psc_q;
    end
    if (bus_addr == ADDR_W'(OFF_IEN)) bus_rdata[IRQ_LSB +: NCH] = ien_q;
    if (bus_addr == ADDR_W'(OFF_STS)) bus_rdata[IRQ_LSB +: NCH] = sts_q;
  end

  assign irq = |(sts_q & ien_q);
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk import cap_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic [NCH-1:0]    hit,
  input logic [NCH-1:0]    sts,
  input logic              irq,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [CNT_W-1:0]  cap0
);
  logic ack_wr;
  assign ack_wr = wr && (addr == ADDR_W'(OFF_ACK));

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (irq == 1'b0 && sts == '0);
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt));

  // R6
  sts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ack_wr) |=> $stable(sts));

  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((sts & $past(hit)) == $past(hit)));

  // R9
  ack_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (&wdata[IRQ_LSB +: NCH]) && !(|hit)) |=> (sts == '0));

  // R3
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (cap0 == $past(cnt)));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|sts));
endmodule

bind cap_unit cap_unit_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run_q), .cnt(cnt_w), .hit(hit_w),
  .sts(sts_q), .irq(irq), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .cap0(capv_q[0])
);

// File: tb/cap_unit_tb_top.sv
`timescale 1ns/1ps
module cap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = 4'h0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int rr = 0;

  always #2 clk = ~clk;

  cap_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in), .irq(irq)
  );

  // behavioural reference
  int          m_edge [4];
  bit          m_en;
  int          m_psc;
  int          m_div;
  bit [3:0]    m_ien, m_sts;
  logic [31:0] m_cnt;
  logic [31:0] m_cap [4];
  logic [3:0]  hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_edge[c] = 0; m_cap[c] = 0; end
      m_en = 0; m_psc = 0; m_div = 0; m_ien = 0; m_sts = 0; m_cnt = 0;
      hist = '{4'h0, 4'h0, 4'h0};
    end else begin
      logic [3:0] s2, pv, hit;
      s2 = hist[1];
      pv = hist[2];
      hit = 0;
      for (int c = 0; c < 4; c++) begin
        case (m_edge[c])
          1: hit[c] = s2[c] & ~pv[c];
          2: hit[c] = ~s2[c] & pv[c];
          3: hit[c] = s2[c] ^ pv[c];
          default: hit[c] = 1'b0;
        endcase
        if (!m_en) hit[c] = 1'b0;
        if (hit[c]) m_cap[c] = m_cnt;
      end
      if (m_en) begin
        if (m_div == m_psc) begin m_div = 0; m_cnt = m_cnt + 1; end
        else m_div = m_div + 1;
      end else m_div = 0;
      if (bus_wr) begin
        if (bus_addr == 8'h5C) m_sts = m_sts & ~bus_wdata[4:1];
        if (bus_addr == 8'h50) begin m_en = bus_wdata[10]; m_psc = int'(bus_wdata[8:4]); end
        if (bus_addr == 8'h54) m_ien = bus_wdata[4:1];
        for (int c = 0; c < 4; c++)
          if (bus_addr == 8'(8'h30 + 4 * c)) m_edge[c] = int'(bus_wdata[1:0]);
      end
      m_sts = m_sts | hit;
      hist.push_front(cap_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = 0;
    for (int c = 0; c < 4; c++) begin
      if (a == 8'(8'h10 + 4 * c)) v = m_cap[c];
      if (a == 8'(8'h30 + 4 * c)) v = 32'(m_edge[c]);
    end
    if (a == 8'h50) begin v[10] = m_en; v[8:4] = 5'(m_psc); end
    if (a == 8'h54) v[4:1] = m_ien;
    if (a == 8'h58) v[4:1] = m_sts;
    return v;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (!rst_n) return "R1";
    if (a >= 8'h10 && a <= 8'h1C) return "R3 R4 R5";
    if (a >= 8'h30 && a <= 8'h3C) return "R2";
    if (a == 8'h58) return "R6 R7 R9";
    return "R10";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] exp_rd;
      logic        exp_irq;
      exp_rd = m_read(bus_addr);
      exp_irq = |(m_sts & m_ien);
      checks++;
      if (bus_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", tag_of(bus_addr), bus_addr, bus_rdata, exp_rd);
      end
      checks++;
      if (irq !== exp_irq) begin
        fails++;
        $display("FAIL %s irq actual=%0b expected=%0b", rst_n ? "R8" : "R1", irq, exp_irq);
      end
    end
  end

  function automatic logic [7:0] rr_addr(input int i);
    if (i < 4) return 8'(8'h10 + 4 * i);
    if (i < 8) return 8'(8'h30 + 4 * (i - 4));
    case (i)
      8: return 8'h50;
      9: return 8'h54;
      10: return 8'h58;
      11: return 8'h5C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      bus_addr = rr_addr(rr);
      rr = (rr + 1) % 13;
      @(posedge clk); #1;
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] v, input int hold);
    cap_in = v;
    idle(hold);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state across the register space
    for (int i = 0; i < 13; i++) begin
      bus_addr = rr_addr(i);
      #4;
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(13);

    // R2 R10: selectors and control readback, garbage in unused bits
    bw(8'h30, 32'hFFFF_FFF1);
    bw(8'h34, 32'h2);
    bw(8'h38, 32'h3);
    bw(8'h3C, 32'h0);
    bw(8'h50, 32'hFFFF_FBFF & ~32'h0000_01F0);
    idle(13);
    bw(8'h00, 32'hFFFF_FFFF);
    bw(8'h54, 32'h0000_001E);

    // R5 R3: run with prescale 0, mixed edges
    bw(8'h50, 32'h0000_0400);
    idle(5);
    pulse(4'b0101, 7);
    pulse(4'b1010, 9);
    pulse(4'b0000, 6);
    pulse(4'b1111, 13);
    bw(8'h5C, 32'h0000_01FF);
    idle(13);

    // R5: prescale 3
    bw(8'h50, 32'h0000_0430);
    idle(11);
    pulse(4'b0110, 17);
    pulse(4'b0001, 13);
    pulse(4'b0111, 26);

    // R6 R5: stop, toggle, restart
    bw(8'h5C, 32'h0000_01FF);
    bw(8'h50, 32'h0000_0030);
    pulse(4'b1001, 13);
    pulse(4'b0000, 13);
    bw(8'h50, 32'h0000_0410);
    idle(7);
    pulse(4'b1111, 13);

    // R7 R8: status without enable, partial enables
    bw(8'h54, 32'h0);
    pulse(4'b0000, 13);
    bw(8'h54, 32'h0000_0004);
    idle(6);
    bw(8'h54, 32'h0000_0010);
    idle(6);

    // R9: partial clear, then acknowledge colliding with a capture
    bw(8'h5C, 32'h0000_0006);
    idle(13);
    bw(8'h54, 32'h0000_001E);
    cap_in = 4'b0100;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bw(8'h5C, 32'h0000_01FF);
    idle(13);

    // R2: reprogram selector in the cycle its edge is detected
    cap_in = 4'b0000;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bw(8'h38, 32'h1);
    idle(13);
    pulse(4'b0100, 13);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule